// File: doc/BRIEF.md
# Three-Wide Instruction Group Former

This block sits between a pre-decoded instruction queue and a three-wide in-order integer pipeline. Each cycle it looks at the three candidates at the queue head and decides how many of them, from zero to three, issue together as one group. Slot 0 is always the oldest candidate. A group can end after an instruction, for example after a control transfer or an exception. A group can also end before an instruction, for example before a second memory reference, a second shift, a write-port overflow or a forbidden use of a cascaded result.

The block keeps a small record of the group it issued last. The record holds each destination register and a flag that marks whether that destination came from a cascade. It also remembers whether that group ended with an annulled branch. With this record the block can stall a memory reference that needs a cascade result from the previous group. It can also limit the delay group of an annulled branch to one instruction.

The issue count is registered. For candidates presented before a rising edge, the count appears after that edge. The record updates on the same edge. The queue consumes exactly the entries counted.

Top module: `group_former`

## Requirements
- R1: At most three candidates issue per group, always taken from the head. The count stops at the first slot whose `cand_valid` bit is 0, so an empty head gives 0.
- R2: A group ends after any control-transfer instruction (`cand_cti`). The instruction that follows it starts the next group.
- R3: A group holds at most one memory reference (`cand_mem`). A second one breaks the group before it.
- R4: A group holds at most one shift (`cand_shift`). A second one breaks the group before it.
- R5: Slot s requests `cand_wp[2s+1:2s]` integer write ports: 0 for a store, a branch or a floating-point load, 1 for an arithmetic operation or an integer load, 2 for a double integer load. The group breaks before the slot that would push the running total above 2.
- R6: A cascade is an arithmetic slot (`cand_alu`) that reads the destination of an earlier arithmetic slot in the same group. A source is `cand_rs1` or `cand_rs2`, and a destination counts only when that slot's port demand is nonzero. A group holds at most one cascade.
- R7: A shift, a register-indirect jump (`cand_ijmp`) or a memory reference that reads a cascade's destination breaks the group before it. A memory reference that reads a plain, non-cascade arithmetic result in the same group is allowed.
- R8: A group ends after the first slot whose `cand_exc` bit is set. That slot itself still issues.
- R9: A group ends after a cascade whose consumer sets condition codes (`cand_setcc`).
- R10: A memory reference that reads a cascade destination issued in the previous group breaks the group before it. In slot 0 this gives an issue count of 0. A cycle that issues nothing, without a stall, clears the destination record.
- R11: When the last issued instruction is an annulled branch (`cand_cti` and `cand_annul`), the next group that issues holds at most one instruction. This limit lasts through empty cycles until that group issues.
- R12: Register index 0 never creates a dependency, whether within a group or against the previous group.
- R13: With `stall` high, the count is 0 and the record holds. With `flush` high, the count is 0 and the record is cleared, including the annulled-branch limit.
- R14: `issue_cnt` is 0 after reset. It changes only on the rising edge that follows the cycle in which the candidates were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline cannot accept a group; issue nothing, hold record |
| flush | input | 1 | Discard state; issue nothing, clear record |
| cand_valid | input | 3 | Slot holds a candidate (bit s = slot s, slot 0 oldest) |
| cand_alu | input | 3 | Slot is an arithmetic operation |
| cand_mem | input | 3 | Slot is a load or store |
| cand_shift | input | 3 | Slot is a shift |
| cand_cti | input | 3 | Slot is a control transfer |
| cand_ijmp | input | 3 | Slot is a register-indirect jump |
| cand_annul | input | 3 | Control transfer annuls its delay instruction |
| cand_setcc | input | 3 | Slot sets condition codes |
| cand_exc | input | 3 | Slot carries an instruction-access exception |
| cand_wp | input | 6 | Write-port demand, 2 bits per slot |
| cand_rs1 | input | 15 | First source register, 5 bits per slot |
| cand_rs2 | input | 15 | Second source register, 5 bits per slot |
| cand_rd | input | 15 | Destination register, 5 bits per slot |
| issue_cnt | output | 2 | Number of head candidates issued |

## Verification
Every issue count is due on the first rising edge after its candidates are presented. Record effects, such as a previous-group cascade hazard, the annulled-delay limit and the hold on stall, show up in the count of the group presented after that. The bench drives inputs on the falling edge and samples `issue_cnt` on the falling edge after the next rising edge. One check samples just before that rising edge to confirm the count has not yet moved. Each scenario begins with an empty cycle that must give 0. This clears the destination record, so a test does not inherit a hazard from the test before it.

// File: rtl/gf_pkg.sv
package gf_pkg;
  // Update applied to the previous-group record at a clock edge
  typedef enum logic [1:0] {
    REC_HOLD  = 2'd0,
    REC_CLEAR = 2'd1,
    REC_LOAD  = 2'd2,
    REC_WIPE  = 2'd3
  } rec_op_t;
endpackage

// File: rtl/gf_dep_matrix.sv
// Pairwise read-after-write hits between candidate slots of one group.
// raw[i*SLOTS+j] is set when slot j (older, j<i) writes a register read by slot i.
module gf_dep_matrix #(
  parameter int SLOTS = 3,
  parameter int RW    = 5,
  parameter int WPW   = 2
) (
  input  logic [SLOTS*RW-1:0]    rs1,
  input  logic [SLOTS*RW-1:0]    rs2,
  input  logic [SLOTS*RW-1:0]    rd,
  input  logic [SLOTS*WPW-1:0]   wp,
  output logic [SLOTS*SLOTS-1:0] raw
);
  genvar gi, gj;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_cons
      for (gj = 0; gj < SLOTS; gj++) begin : g_prod
        if (gj < gi) begin : g_lower
          logic writes;
          assign writes = (wp[gj*WPW +: WPW] != '0) && (rd[gj*RW +: RW] != '0);
          assign raw[gi*SLOTS+gj] = writes &&
                                    ((rs1[gi*RW +: RW] == rd[gj*RW +: RW]) ||
                                     (rs2[gi*RW +: RW] == rd[gj*RW +: RW]));
        end else begin : g_upper
          assign raw[gi*SLOTS+gj] = 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/gf_prev_record.sv
// Record of the last issued group: destinations, cascade flags, annulled-branch tail.
module gf_prev_record
  import gf_pkg::*;
#(
  parameter int SLOTS = 3,
  parameter int RW    = 5,
  parameter int WPW   = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall,
  input  logic                 flush,
  input  logic [SLOTS-1:0]     take,
  input  logic [SLOTS-1:0]     casc,
  input  logic [SLOTS-1:0]     mem,
  input  logic [SLOTS-1:0]     cti,
  input  logic [SLOTS-1:0]     annul,
  input  logic [SLOTS*WPW-1:0] wp,
  input  logic [SLOTS*RW-1:0]  rs1,
  input  logic [SLOTS*RW-1:0]  rs2,
  input  logic [SLOTS*RW-1:0]  rd,
  output logic [SLOTS-1:0]     prev_haz,
  output logic                 annul_pend
);
  logic [SLOTS-1:0]    rec_wr;
  logic [SLOTS-1:0]    rec_casc;
  logic [SLOTS*RW-1:0] rec_rd;
  logic                annul_q;
  rec_op_t             op;
  logic [SLOTS-1:0]    take_nx;
  logic [SLOTS-1:0]    last;
  logic [SLOTS-1:0]    wr_now;
  logic                last_annul;

  always_comb begin
    if (rst || flush)   op = REC_WIPE;
    else if (stall)     op = REC_HOLD;
    else if (|take)     op = REC_LOAD;
    else                op = REC_CLEAR;
  end

  assign take_nx    = {1'b0, take[SLOTS-1:1]};
  assign last       = take & ~take_nx;
  assign last_annul = |(last & annul & cti);

  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      wr_now[s] = take[s] && (wp[s*WPW +: WPW] != '0) && (rd[s*RW +: RW] != '0);
    end
  end

  always_ff @(posedge clk) begin
    case (op)
      REC_WIPE: begin
        rec_wr   <= '0;
        rec_casc <= '0;
        rec_rd   <= '0;
        annul_q  <= 1'b0;
      end
      REC_LOAD: begin
        rec_wr   <= wr_now;
        rec_casc <= casc & take;
        rec_rd   <= rd;
        annul_q  <= last_annul;
      end
      REC_CLEAR: begin
        rec_wr   <= '0;
        rec_casc <= '0;
      end
      default: ;
    endcase
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic hit;
      hit = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
        if (rec_wr[k] && rec_casc[k] &&
            ((rs1[i*RW +: RW] == rec_rd[k*RW +: RW]) ||
             (rs2[i*RW +: RW] == rec_rd[k*RW +: RW])))
          hit = 1'b1;
      end
      prev_haz[i] = mem[i] && hit;
    end
  end

  assign annul_pend = annul_q;
endmodule

// File: rtl/gf_break_logic.sv
// Applies the break-before and break-after rules slot by slot from the head.
module gf_break_logic #(
  parameter int SLOTS = 3,
  parameter int WPW   = 2,
  parameter int PORTS = 2
) (
  input  logic [SLOTS-1:0]       valid,
  input  logic [SLOTS-1:0]       alu,
  input  logic [SLOTS-1:0]       mem,
  input  logic [SLOTS-1:0]       shift,
  input  logic [SLOTS-1:0]       cti,
  input  logic [SLOTS-1:0]       ijmp,
  input  logic [SLOTS-1:0]       setcc,
  input  logic [SLOTS-1:0]       exc,
  input  logic [SLOTS*WPW-1:0]   wp,
  input  logic [SLOTS*SLOTS-1:0] raw,
  input  logic [SLOTS-1:0]       prev_haz,
  input  logic                   annul_pend,
  output logic [SLOTS-1:0]       take,
  output logic [SLOTS-1:0]       casc
);
  localparam int SUMW = $clog2(SLOTS * ((1 << WPW) - 1) + 1);

  logic [SLOTS-1:0] feed;

  // Cascade detection and cascade-result consumers
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      logic dep_alu;
      logic dep_casc;
      dep_alu  = 1'b0;
      dep_casc = 1'b0;
      for (int j = 0; j < SLOTS; j++) begin
        if (j < i && raw[i*SLOTS+j] && alu[j]) dep_alu = 1'b1;
      end
      casc[i] = alu[i] && dep_alu;
      for (int j = 0; j < SLOTS; j++) begin
        if (j < i && raw[i*SLOTS+j] && casc[j]) dep_casc = 1'b1;
      end
      feed[i] = (shift[i] || ijmp[i] || mem[i]) && dep_casc;
    end
  end

  // Walk from the head; the first blocked slot ends the group
  always_comb begin
    logic [SUMW-1:0] used;
    logic seen_mem, seen_shift, seen_casc, end_after, stopped, blk;
    used       = '0;
    seen_mem   = 1'b0;
    seen_shift = 1'b0;
    seen_casc  = 1'b0;
    end_after  = 1'b0;
    stopped    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      used = used + SUMW'(wp[i*WPW +: WPW]);
      blk  = !valid[i] || prev_haz[i];
      if (i > 0) begin
        blk = blk || end_after || annul_pend ||
              (used > SUMW'(PORTS)) ||
              (mem[i] && seen_mem) ||
              (shift[i] && seen_shift) ||
              (casc[i] && seen_casc) ||
              feed[i];
      end
      stopped    = stopped || blk;
      take[i]    = !stopped;
      seen_mem   = seen_mem || mem[i];
      seen_shift = seen_shift || shift[i];
      seen_casc  = seen_casc || casc[i];
      end_after  = cti[i] || exc[i] || (casc[i] && setcc[i]);
    end
  end
endmodule

// File: rtl/group_former.sv
module group_former #(
  parameter int SLOTS = 3,
  parameter int RW    = 5,
  parameter int WPW   = 2,
  parameter int PORTS = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           stall,
  input  logic                           flush,
  input  logic [SLOTS-1:0]               cand_valid,
  input  logic [SLOTS-1:0]               cand_alu,
  input  logic [SLOTS-1:0]               cand_mem,
  input  logic [SLOTS-1:0]               cand_shift,
  input  logic [SLOTS-1:0]               cand_cti,
  input  logic [SLOTS-1:0]               cand_ijmp,
  input  logic [SLOTS-1:0]               cand_annul,
  input  logic [SLOTS-1:0]               cand_setcc,
  input  logic [SLOTS-1:0]               cand_exc,
  input  logic [SLOTS*WPW-1:0]           cand_wp,
  input  logic [SLOTS*RW-1:0]            cand_rs1,
  input  logic [SLOTS*RW-1:0]            cand_rs2,
  input  logic [SLOTS*RW-1:0]            cand_rd,
  output logic [$clog2(SLOTS+1)-1:0]     issue_cnt
);
  localparam int CW = $clog2(SLOTS + 1);

  logic [SLOTS*SLOTS-1:0] raw;
  logic [SLOTS-1:0]       take;
  logic [SLOTS-1:0]       casc;
  logic [SLOTS-1:0]       prev_haz;
  logic                   annul_pend;
  logic [CW-1:0]          cnt;

  gf_dep_matrix #(.SLOTS(SLOTS), .RW(RW), .WPW(WPW)) u_dep (
    .rs1 (cand_rs1),
    .rs2 (cand_rs2),
    .rd  (cand_rd),
    .wp  (cand_wp),
    .raw (raw)
  );

  gf_break_logic #(.SLOTS(SLOTS), .WPW(WPW), .PORTS(PORTS)) u_brk (
    .valid      (cand_valid),
    .alu        (cand_alu),
    .mem        (cand_mem),
    .shift      (cand_shift),
    .cti        (cand_cti),
    .ijmp       (cand_ijmp),
    .setcc      (cand_setcc),
    .exc        (cand_exc),
    .wp         (cand_wp),
    .raw        (raw),
    .prev_haz   (prev_haz),
    .annul_pend (annul_pend),
    .take       (take),
    .casc       (casc)
  );

  gf_prev_record #(.SLOTS(SLOTS), .RW(RW), .WPW(WPW)) u_rec (
    .clk        (clk),
    .rst        (rst),
    .stall      (stall),
    .flush      (flush),
    .take       (take),
    .casc       (casc),
    .mem        (cand_mem),
    .cti        (cand_cti),
    .annul      (cand_annul),
    .wp         (cand_wp),
    .rs1        (cand_rs1),
    .rs2        (cand_rs2),
    .rd         (cand_rd),
    .prev_haz   (prev_haz),
    .annul_pend (annul_pend)
  );

  // take is contiguous from slot 0, so its population is the count
  always_comb begin
    cnt = '0;
    for (int i = 0; i < SLOTS; i++) cnt = cnt + CW'(take[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)                 issue_cnt <= '0;
    else if (stall || flush) issue_cnt <= '0;
    else                     issue_cnt <= cnt;
  end
endmodule

// File: rtl/gf_checker.sv
module gf_checker #(
  parameter int SLOTS = 3,
  parameter int WPW   = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       stall,
  input logic                       flush,
  input logic [SLOTS-1:0]           cand_valid,
  input logic [SLOTS-1:0]           cand_mem,
  input logic [SLOTS-1:0]           cand_shift,
  input logic [SLOTS-1:0]           cand_cti,
  input logic [SLOTS-1:0]           cand_exc,
  input logic [SLOTS*WPW-1:0]       cand_wp,
  input logic [$clog2(SLOTS+1)-1:0] issue_cnt
);
  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (rst)
    !cand_valid[0] |=> issue_cnt == '0); // R1
  AST_CTI_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cand_valid[0] && cand_cti[0]) |=> issue_cnt <= 1); // R2
  AST_ONE_MEM: assert property (@(posedge clk) disable iff (rst)
    (cand_mem[0] && cand_mem[1]) |=> issue_cnt <= 1); // R3
  AST_ONE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (cand_shift[0] && cand_shift[1]) |=> issue_cnt <= 1); // R4
  AST_PORT_BUDGET: assert property (@(posedge clk) disable iff (rst)
    ((cand_wp[WPW-1:0] == WPW'(2)) && (cand_wp[2*WPW-1:WPW] != '0)) |=> issue_cnt <= 1); // R5
  AST_EXC_ENDS: assert property (@(posedge clk) disable iff (rst)
    (cand_valid[0] && cand_exc[0]) |=> issue_cnt <= 1); // R8
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> issue_cnt == '0); // R13
  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (rst)
    flush |=> issue_cnt == '0); // R13
endmodule

bind group_former gf_checker #(.SLOTS(SLOTS), .WPW(WPW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .stall      (stall),
  .flush      (flush),
  .cand_valid (cand_valid),
  .cand_mem   (cand_mem),
  .cand_shift (cand_shift),
  .cand_cti   (cand_cti),
  .cand_exc   (cand_exc),
  .cand_wp    (cand_wp),
  .issue_cnt  (issue_cnt)
);

// File: tb/sim_group_former.sv
module sim_group_former;
  logic        clk = 1'b0;
  logic        rst, stall, flush;
  logic [2:0]  v, alu, mem, sh, cti, ij, an, cc, ex;
  logic [5:0]  wp;
  logic [14:0] r1, r2, rd;
  logic [1:0]  issue_cnt;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  group_former u0 (
    .clk(clk), .rst(rst), .stall(stall), .flush(flush),
    .cand_valid(v), .cand_alu(alu), .cand_mem(mem), .cand_shift(sh),
    .cand_cti(cti), .cand_ijmp(ij), .cand_annul(an), .cand_setcc(cc),
    .cand_exc(ex), .cand_wp(wp), .cand_rs1(r1), .cand_rs2(r2),
    .cand_rd(rd), .issue_cnt(issue_cnt)
  );

  task automatic clr();
    v = '0; alu = '0; mem = '0; sh = '0; cti = '0; ij = '0; an = '0;
    cc = '0; ex = '0; wp = '0; r1 = '0; r2 = '0; rd = '0;
  endtask

  task automatic p_alu(int s, int d, int a, int b, int w, bit setc = 1'b0);
    v[s] = 1'b1; alu[s] = 1'b1; cc[s] = setc;
    rd[s*5 +: 5] = 5'(d); r1[s*5 +: 5] = 5'(a); r2[s*5 +: 5] = 5'(b);
    wp[s*2 +: 2] = 2'(w);
  endtask

  task automatic p_mem(int s, int a, int d, int w);
    v[s] = 1'b1; mem[s] = 1'b1;
    rd[s*5 +: 5] = 5'(d); r1[s*5 +: 5] = 5'(a); wp[s*2 +: 2] = 2'(w);
  endtask

  task automatic p_shift(int s, int d, int a);
    v[s] = 1'b1; sh[s] = 1'b1;
    rd[s*5 +: 5] = 5'(d); r1[s*5 +: 5] = 5'(a); wp[s*2 +: 2] = 2'd1;
  endtask

  task automatic p_br(int s, bit annul);
    v[s] = 1'b1; cti[s] = 1'b1; an[s] = annul;
  endtask

  task automatic p_ijmp(int s, int a);
    v[s] = 1'b1; cti[s] = 1'b1; ij[s] = 1'b1; r1[s*5 +: 5] = 5'(a);
  endtask

  task automatic expect_cnt(int exp, string req);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (issue_cnt !== 2'(exp)) begin
      errors++;
      $display("FAIL %s: issue_cnt=%0d expected %0d", req, issue_cnt, exp);
    end
  endtask

  task automatic idle(string req);
    clr();
    expect_cnt(0, req);
  endtask

  // Three independent candidates within the port budget
  task automatic full_group();
    clr();
    p_alu(0, 1, 2, 3, 1);
    p_alu(1, 4, 2, 3, 1);
    p_mem(2, 20, 0, 0);
  endtask

  task automatic t_reset_latency();
    checks++;
    if (issue_cnt !== 2'd0) begin
      errors++;
      $display("FAIL R14: issue_cnt=%0d expected 0 after reset", issue_cnt);
    end
    full_group();
    #5;
    checks++;
    if (issue_cnt !== 2'd0) begin
      errors++;
      $display("FAIL R14: issue_cnt=%0d expected 0 before edge", issue_cnt);
    end
    expect_cnt(3, "R14");
  endtask

  task automatic t_head_valid();
    idle("R1");
    full_group(); expect_cnt(3, "R1");
    full_group(); v[2] = 1'b0; expect_cnt(2, "R1");
    full_group(); v[1] = 1'b0; expect_cnt(1, "R1");
  endtask

  task automatic t_cti();
    idle("R2");
    clr(); p_br(0, 1'b0); p_alu(1, 1, 2, 3, 1); p_mem(2, 20, 0, 0);
    expect_cnt(1, "R2");
    clr(); p_alu(0, 1, 2, 3, 1); p_br(1, 1'b0); p_mem(2, 20, 0, 0);
    expect_cnt(2, "R2");
  endtask

  task automatic t_mem_shift();
    idle("R3");
    clr(); p_mem(0, 20, 0, 0); p_alu(1, 1, 2, 3, 1); p_mem(2, 21, 0, 0);
    expect_cnt(2, "R3");
    clr(); p_mem(0, 20, 0, 0); p_mem(1, 21, 0, 0); p_alu(2, 1, 2, 3, 1);
    expect_cnt(1, "R3");
    clr(); p_shift(0, 1, 2); p_shift(1, 4, 2); p_mem(2, 20, 0, 0);
    expect_cnt(1, "R4");
  endtask

  task automatic t_ports();
    idle("R5");
    clr(); p_alu(0, 1, 2, 3, 1); p_alu(1, 4, 2, 3, 1); p_alu(2, 7, 2, 3, 1);
    expect_cnt(2, "R5");
    clr(); p_mem(0, 20, 1, 2); p_alu(1, 4, 2, 3, 1);
    expect_cnt(1, "R5");
    clr(); p_mem(0, 20, 0, 0); p_alu(1, 4, 2, 3, 1); p_alu(2, 7, 2, 3, 1);
    expect_cnt(3, "R5");
  endtask

  task automatic t_cascade();
    idle("R6");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_mem(2, 20, 0, 0);
    expect_cnt(3, "R6");
    idle("R6");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_alu(2, 0, 6, 0, 0);
    expect_cnt(2, "R6");
    idle("R6");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_alu(2, 0, 5, 0, 0);
    expect_cnt(2, "R6");
  endtask

  task automatic t_cascade_feed();
    idle("R7");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_mem(2, 6, 0, 0);
    expect_cnt(2, "R7");
    idle("R7");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_ijmp(2, 6);
    expect_cnt(2, "R7");
    idle("R7");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1); p_ijmp(2, 20);
    expect_cnt(3, "R7");
    idle("R7");
    clr(); p_alu(0, 5, 2, 3, 1); p_mem(1, 5, 0, 0); p_alu(2, 7, 2, 3, 1);
    expect_cnt(3, "R7");
  endtask

  task automatic t_exc_setcc();
    idle("R8");
    full_group(); ex[0] = 1'b1; expect_cnt(1, "R8");
    full_group(); ex[1] = 1'b1; expect_cnt(2, "R8");
    idle("R9");
    clr(); p_alu(0, 5, 2, 3, 1); p_alu(1, 6, 5, 0, 1, 1'b1); p_mem(2, 20, 0, 0);
    expect_cnt(2, "R9");
  endtask

  task automatic t_prev_cascade();
    idle("R10");
    clr(); p_alu(0, 8, 2, 3, 1); p_alu(1, 9, 8, 0, 1); expect_cnt(2, "R10");
    clr(); p_mem(0, 9, 3, 1); p_alu(1, 4, 0, 0, 1); expect_cnt(0, "R10");
    expect_cnt(2, "R10");
    clr(); p_alu(0, 8, 2, 3, 1); p_alu(1, 9, 8, 0, 1); expect_cnt(2, "R10");
    clr(); p_alu(0, 10, 2, 3, 1); p_mem(1, 9, 0, 0); expect_cnt(1, "R10");
    idle("R10");
    clr(); p_alu(0, 11, 2, 3, 1); expect_cnt(1, "R10");
    clr(); p_mem(0, 11, 12, 1); p_alu(1, 4, 2, 3, 1); expect_cnt(2, "R10");
  endtask

  task automatic t_annul();
    idle("R11");
    clr(); p_br(0, 1'b1); expect_cnt(1, "R11");
    full_group(); expect_cnt(1, "R11");
    full_group(); expect_cnt(3, "R11");
    clr(); p_br(0, 1'b1); expect_cnt(1, "R11");
    idle("R11");
    full_group(); expect_cnt(1, "R11");
    clr(); p_br(0, 1'b0); expect_cnt(1, "R11");
    full_group(); expect_cnt(3, "R11");
  endtask

  task automatic t_zero_reg();
    idle("R12");
    clr(); p_alu(0, 0, 2, 3, 1); p_alu(1, 12, 0, 0, 1); p_alu(2, 0, 0, 0, 0);
    expect_cnt(3, "R12");
  endtask

  task automatic t_stall_flush();
    idle("R13");
    clr(); p_alu(0, 8, 2, 3, 1); p_alu(1, 9, 8, 0, 1); expect_cnt(2, "R13");
    clr(); p_mem(0, 9, 3, 1); p_alu(1, 4, 0, 0, 1);
    stall = 1'b1; expect_cnt(0, "R13");
    stall = 1'b0; expect_cnt(0, "R13");
    expect_cnt(2, "R13");
    clr(); p_alu(0, 8, 2, 3, 1); p_alu(1, 9, 8, 0, 1); expect_cnt(2, "R13");
    clr(); p_mem(0, 9, 3, 1); p_alu(1, 4, 0, 0, 1);
    flush = 1'b1; expect_cnt(0, "R13");
    flush = 1'b0; expect_cnt(2, "R13");
    clr(); p_br(0, 1'b1); expect_cnt(1, "R13");
    clr(); flush = 1'b1; expect_cnt(0, "R13");
    flush = 1'b0; full_group(); expect_cnt(3, "R13");
  endtask

  initial begin
    rst = 1'b1; stall = 1'b0; flush = 1'b0;
    clr();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_latency();
    t_head_valid();
    t_cti();
    t_mem_shift();
    t_ports();
    t_cascade();
    t_cascade_feed();
    t_exc_setcc();
    t_prev_cascade();
    t_annul();
    t_zero_reg();
    t_stall_flush();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule